// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that software drives through a small word-wide register bus. Software chooses a clock divider, a clock mode and one of three select lines, sets the run bit, and then feeds bytes into a transmit queue through a data port. A shift engine takes bytes from that queue one at a time. It moves each byte out on MOSI, most significant bit first, and collects the byte arriving on MISO into a receive queue. Software reads the receive queue back through the same data port.

Each queue holds 16 bytes. A status word reports whether the transmit queue still has room, whether received bytes are waiting, whether the receive queue has reached its high-water mark or is full, and whether the transfer has drained. Two interrupt enables turn the drained condition and the high-water condition into an interrupt line. When the receive queue is full, the shift engine holds its finished byte instead of dropping it. The engine continues once software has read a byte out.

Register map (word address on `bus_addr`): 0 is control/status, 1 is the data port, 2 is the clock divider. Address 3 reads as zero and ignores writes.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset all three select lines are high, SCLK is low, the interrupt is low, and the status word shows bit 18 (transmit room) = 1, bit 17 (receive data waiting) = 0 and bit 16 (drained) = 0.
- R2: The SCLK period in core clock cycles equals the divider register's low 16 bits, with an odd value rounded down to the even value below it. The values 0 and 1 both select 65536.
- R3: Control bit 3 sets the SCLK idle level. With control bit 2 = 0, MISO is sampled on the leading SCLK edge of each bit and MOSI changes on the trailing edge. With bit 2 = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Bytes go out most significant bit first.
- R4: Control bits 1:0 pick the select line (0 to 2). Select line k is active at level (bit 21+k OR bit 6) and is idle at the opposite level. Only the picked line is active, and only while control bit 7 (run) is 1. Index 3 activates no line.
- R5: Status bit 18 is 1 exactly while the transmit queue has room for another byte, and status bit 17 is 1 exactly while the receive queue holds a byte.
- R6: Writing control with bit 4 = 1 empties the transmit queue, and writing control with bit 5 = 1 empties the receive queue. Both bits read back as 0.
- R7: Status bit 16 (drained) is 1 when run is 1, the transmit queue is empty and the shift engine is idle. Writing a new byte to the data port clears it until that byte has been shifted.
- R8: The interrupt output is high when (control bit 9 AND drained) or (control bit 10 AND status bit 19). Status bit 19 is 1 when the receive queue holds 12 or more bytes.
- R9: Every byte written to the data port yields exactly one received byte, and received bytes are read back in order in bits 7:0 of the data port, with the upper bits zero. Status bit 20 reports a full receive queue. While the queue is full, the engine stalls and loses no byte.
- R10: Clearing run during a byte abandons it. SCLK returns to idle and the select line goes inactive on the next cycle, and no received byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a data-port read pops the receive queue) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Select lines, one per target |

## Verification
Several properties are checked on every cycle. At most one select line is active, and none is active while run is clear. SCLK sits at its idle level in the cycle after run clears. The shift engine never pushes into a full receive queue, and a full queue keeps its contents until it is read. The high-water interrupt also never fires without its enable.

The remaining behaviour can only be shown by the bench's scenarios, which watch the pins against a scoreboard. These scenarios cover bit order and sampling edge in all four clock modes, the SCLK period for odd and even divider values, the divide-by-65536 case, the polarity mixes of the select lines, the status flags across queue fill and flush, the stall with a full receive queue, and the abort of a byte in flight.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
   typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_PUSH} sh_state_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_DIV  = 2'd2;

   localparam int B_CPHA    = 2;
   localparam int B_CPOL    = 3;
   localparam int B_CLR_TX  = 4;
   localparam int B_CLR_RX  = 5;
   localparam int B_GPOL    = 6;
   localparam int B_RUN     = 7;
   localparam int B_IE_DONE = 9;
   localparam int B_IE_HIGH = 10;
   localparam int B_POL_LO  = 21;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [AW:0]      count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_push, do_pop;

   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter
   import spim_pkg::*;
#(
   parameter int BITS  = 8,
   parameter int CNT_W = 15,
   localparam int EDGE_W = $clog2(2*BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cpha,
   input  logic [CNT_W-1:0] half_m1,
   input  logic             tx_empty,
   input  logic [BITS-1:0]  tx_byte,
   output logic             tx_pop,
   input  logic             rx_full,
   output logic             rx_push,
   output logic [BITS-1:0]  rx_byte,
   output logic             phase,
   output logic             mosi,
   input  logic             miso,
   output logic             busy
);
   sh_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [EDGE_W-1:0] edg;
   logic [BITS-1:0]   sh, rxsh;

   assign tx_pop  = en && (state == SH_IDLE) && !tx_empty;
   assign rx_push = en && (state == SH_PUSH) && !rx_full;
   assign rx_byte = rxsh;
   assign busy    = (state != SH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         cnt   <= '0;
         edg   <= '0;
         sh    <= '0;
         rxsh  <= '0;
         phase <= 1'b0;
         mosi  <= 1'b0;
      end else if (!en) begin
         state <= SH_IDLE;
         phase <= 1'b0;
         cnt   <= '0;
         edg   <= '0;
      end else begin
         case (state)
            SH_IDLE: if (!tx_empty) begin
               state <= SH_RUN;
               cnt   <= half_m1;
               edg   <= '0;
               if (cpha) sh <= tx_byte;
               else begin
                  mosi <= tx_byte[BITS-1];
                  sh   <= {tx_byte[BITS-2:0], 1'b0};
               end
            end
            SH_RUN: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
               cnt   <= half_m1;
               phase <= ~phase;
               edg   <= edg + 1'b1;
               if (phase == cpha) rxsh <= {rxsh[BITS-2:0], miso};
               else begin
                  mosi <= sh[BITS-1];
                  sh   <= {sh[BITS-2:0], 1'b0};
               end
               if (edg == EDGE_W'(2*BITS-1)) state <= SH_PUSH;
            end
            SH_PUSH: if (!rx_full) state <= SH_IDLE;
            default: state <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_master_ctrl.sv
`timescale 1ns/1ps
module spi_master_ctrl
   import spim_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int HIGH_WATER = 12,
   parameter int DIV_W      = 16,
   localparam int NUM_CS    = 3,
   localparam int AW        = $clog2(FIFO_DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic [2:0]  spi_cs
);
   if ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0 || FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (HIGH_WATER < 1 || HIGH_WATER > FIFO_DEPTH) begin : g_bad_level
      $error("HIGH_WATER must lie in 1..FIFO_DEPTH");
   end
   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must lie in 2..16");
   end

   logic [1:0]        sel_q;
   logic              cpha_q, cpol_q, gpol_q, run_q, ie_done_q, ie_high_q;
   logic [NUM_CS-1:0] pol_q, cs_lvl;
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-2:0]  half_m1;

   logic            wr_ctrl, wr_data, rd_data;
   logic            flush_tx, flush_rx;
   logic            tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push, rx_pop;
   logic [AW:0]     tx_count, rx_count;
   logic [7:0]      tx_head, rx_head, rx_byte;
   logic            phase, busy, drained, high;
   logic            unused_bus;

   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
   assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
   assign flush_tx = wr_ctrl && bus_wdata[B_CLR_TX];
   assign flush_rx = wr_ctrl && bus_wdata[B_CLR_RX];
   assign rx_pop   = rd_data;
   assign unused_bus = ^{bus_wdata[31:24], bus_wdata[20:11], bus_wdata[8], tx_count};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0; cpha_q <= 1'b0; cpol_q <= 1'b0; gpol_q <= 1'b0;
         run_q <= 1'b0; ie_done_q <= 1'b0; ie_high_q <= 1'b0;
         pol_q <= '0; div_q <= '0;
      end else begin
         if (wr_ctrl) begin
            sel_q     <= bus_wdata[1:0];
            cpha_q    <= bus_wdata[B_CPHA];
            cpol_q    <= bus_wdata[B_CPOL];
            gpol_q    <= bus_wdata[B_GPOL];
            run_q     <= bus_wdata[B_RUN];
            ie_done_q <= bus_wdata[B_IE_DONE];
            ie_high_q <= bus_wdata[B_IE_HIGH];
            pol_q     <= bus_wdata[B_POL_LO +: NUM_CS];
         end
         if (bus_wr && bus_addr == ADDR_DIV) div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   // Half period is div/2 core cycles; the 0 reload wraps to the largest count.
   assign half_m1 = div_q[DIV_W-1:1] - 1'b1;

   spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
      .clk, .rst_n, .flush(flush_tx), .push(wr_data), .din(bus_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty));

   spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
      .clk, .rst_n, .flush(flush_rx), .push(rx_push), .din(rx_byte),
      .pop(rx_pop), .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

   spim_shifter #(.BITS(8), .CNT_W(DIV_W-1)) u_shift (
      .clk, .rst_n, .en(run_q), .cpha(cpha_q), .half_m1,
      .tx_empty, .tx_byte(tx_head), .tx_pop,
      .rx_full, .rx_push, .rx_byte,
      .phase, .mosi(spi_mosi), .miso(spi_miso), .busy);

   assign spi_sclk = cpol_q ^ phase;
   assign drained  = run_q && tx_empty && !busy;
   assign high     = (rx_count >= (AW+1)'(HIGH_WATER));
   assign irq      = (ie_done_q && drained) || (ie_high_q && high);

   for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
      assign cs_lvl[k] = pol_q[k] | gpol_q;
      assign spi_cs[k] = (run_q && sel_q == 2'(k)) ? cs_lvl[k] : ~cs_lvl[k];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_CTRL: begin
            bus_rdata[1:0]                 = sel_q;
            bus_rdata[B_CPHA]              = cpha_q;
            bus_rdata[B_CPOL]              = cpol_q;
            bus_rdata[B_GPOL]              = gpol_q;
            bus_rdata[B_RUN]               = run_q;
            bus_rdata[B_IE_DONE]           = ie_done_q;
            bus_rdata[B_IE_HIGH]           = ie_high_q;
            bus_rdata[16]                  = drained;
            bus_rdata[17]                  = !rx_empty;
            bus_rdata[18]                  = !tx_full;
            bus_rdata[19]                  = high;
            bus_rdata[20]                  = rx_full;
            bus_rdata[B_POL_LO +: NUM_CS]  = pol_q;
         end
         ADDR_DATA: bus_rdata[7:0] = rx_head & {8{!rx_empty}};
         ADDR_DIV:  bus_rdata[DIV_W-1:0] = div_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_checker.sv
`timescale 1ns/1ps
module spim_checker #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        run,
   input logic        cpol,
   input logic        ie_high,
   input logic [2:0]  cs_lvl,
   input logic [2:0]  spi_cs,
   input logic        spi_sclk,
   input logic        irq,
   input logic        rx_push,
   input logic        rx_pop,
   input logic [AW:0] rx_count
);
   assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~(spi_cs ^ cs_lvl)) <= 1);

   assert_idle_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (spi_cs == ~cs_lvl));

   assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (spi_sclk == cpol));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (rx_count < (AW+1)'(DEPTH)));

   assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == (AW+1)'(DEPTH) && !rx_pop && run) |=> (rx_count == (AW+1)'(DEPTH)));

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ie_high) |-> run);
endmodule

bind spi_master_ctrl spim_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .cpol(cpol_q), .ie_high(ie_high_q),
   .cs_lvl(cs_lvl), .spi_cs(spi_cs), .spi_sclk(spi_sclk), .irq(irq),
   .rx_push(rx_push), .rx_pop(rx_pop), .rx_count(rx_count));

// File: tb/spi_master_ctrl_tb.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, spi_sclk, spi_mosi, spi_miso;
   logic [2:0]  spi_cs;

   int checks = 0, fails = 0;
   int cyc = 0, toggles = 0;
   bit finished = 0;

   logic [7:0] exp_mosi[$];
   logic [7:0] exp_rx[$];
   bit         mon_en = 0;
   logic       mon_cpol = 0, mon_cpha = 0;
   logic [7:0] acc = '0;
   int         nbits = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   assign spi_miso = ~spi_mosi;

   spi_master_ctrl u_dut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: rebuild each MOSI byte on the edge where the target samples.
   always @(spi_sclk) begin
      toggles++;
      if (mon_en && (((spi_sclk != mon_cpol) ? 1'b1 : 1'b0) == !mon_cpha)) begin
         acc = {acc[6:0], spi_mosi};
         nbits++;
         if (nbits == 8) begin
            nbits = 0;
            if (exp_mosi.size() == 0) check(0, "R3 mosi unexpected", {24'h0, acc}, 0);
            else begin
               automatic logic [7:0] e = exp_mosi.pop_front();
               check(acc == e, "R3 mosi byte", {24'h0, acc}, {24'h0, e});
            end
         end
      end
   end

   function automatic logic [31:0] ctl(input int sel, input bit cpha, input bit cpol,
                                       input bit run, input bit ie_d, input bit ie_h,
                                       input logic [2:0] pol, input bit gpol,
                                       input bit ctx, input bit crx);
      logic [31:0] w = '0;
      w[1:0] = 2'(sel); w[2] = cpha; w[3] = cpol; w[4] = ctx; w[5] = crx;
      w[6] = gpol; w[7] = run; w[9] = ie_d; w[10] = ie_h; w[23:21] = pol;
      return w;
   endfunction

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, input bit pop, output logic [31:0] v);
      @(negedge clk); bus_addr = a; bus_rd = pop;
      #1 v = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      exp_mosi.push_back(b);
      exp_rx.push_back(~b);
      bus_write(2'd1, {24'h0, b});
   endtask

   task automatic drain(input int n);
      logic [31:0] v;
      for (int i = 0; i < n; i++) begin
         bus_read(2'd1, 1, v);
         if (exp_rx.size() == 0) check(0, "R9 rx unexpected", v, 0);
         else begin
            automatic logic [7:0] e = exp_rx.pop_front();
            check(v == {24'h0, e}, "R9 rx byte", v, {24'h0, e});
         end
      end
   endtask

   task automatic wait_drained(input string req);
      logic [31:0] v;
      int i;
      for (i = 0; i < 3000; i++) begin
         bus_read(2'd0, 0, v);
         if (v[16]) break;
      end
      check(v[16] == 1'b1, req, {31'h0, v[16]}, 1);
   endtask

   task automatic run_mode(input int sel, input bit cpha, input bit cpol, input logic [7:0] b0, input logic [7:0] b1);
      bus_write(2'd0, ctl(sel, cpha, cpol, 0, 0, 0, 3'b000, 0, 0, 0));
      @(negedge clk);
      check(spi_sclk == cpol, "R3 idle level", {31'h0, spi_sclk}, {31'h0, cpol});
      mon_cpol = cpol; mon_cpha = cpha; nbits = 0; mon_en = 1;
      bus_write(2'd0, ctl(sel, cpha, cpol, 1, 0, 0, 3'b000, 0, 0, 0));
      check(spi_cs == ~(3'b001 << sel), "R4 select", {29'h0, spi_cs}, {29'h0, ~(3'b001 << sel)});
      send(b0); send(b1);
      wait_drained("R7 drained after bytes");
      drain(2);
      mon_en = 0;
      bus_write(2'd0, ctl(sel, cpha, cpol, 0, 0, 0, 3'b000, 0, 0, 0));
   endtask

   initial begin
      #800000;
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int t0, t1, tg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(spi_cs == 3'b111, "R1 selects idle", {29'h0, spi_cs}, 32'h7);
      check(spi_sclk == 0 && irq == 0, "R1 sclk/irq", {30'h0, spi_sclk, irq}, 0);
      bus_read(2'd0, 0, v);
      check(v[18:16] == 3'b100, "R1 status", {29'h0, v[18:16]}, 32'h4);

      // R3/R9: all four modes, loopback inverted
      bus_write(2'd2, 32'd2);
      run_mode(0, 0, 0, 8'hA5, 8'h3C);
      run_mode(1, 1, 0, 8'h81, 8'h7E);
      run_mode(2, 0, 1, 8'h01, 8'hFF);
      run_mode(0, 1, 1, 8'hC3, 8'h5A);

      // R2: odd divider rounds down, even divider kept
      bus_write(2'd2, 32'd7);
      bus_write(2'd0, ctl(0, 0, 0, 1, 0, 0, 3'b000, 0, 0, 0));
      mon_cpol = 0; mon_cpha = 0; nbits = 0; mon_en = 1;
      send(8'h96);
      @(posedge spi_sclk); t0 = cyc;
      @(posedge spi_sclk); t1 = cyc;
      check(t1 - t0 == 6, "R2 divider 7", t1 - t0, 6);
      wait_drained("R7 drained div7");
      drain(1);
      bus_write(2'd2, 32'd10);
      send(8'h4B);
      @(posedge spi_sclk); t0 = cyc;
      @(posedge spi_sclk); t1 = cyc;
      check(t1 - t0 == 10, "R2 divider 10", t1 - t0, 10);
      wait_drained("R7 drained div10");
      drain(1);
      mon_en = 0;

      // R2/R10: divider 0 is 65536, then abort the byte in flight
      bus_write(2'd2, 32'd0);
      tg = toggles;
      bus_write(2'd1, 32'h0000_0011);
      repeat (3000) @(negedge clk);
      check(toggles == tg, "R2 divider 0 no edge yet", toggles - tg, 0);
      bus_read(2'd0, 0, v);
      check(v[16] == 0, "R7 not drained mid-byte", {31'h0, v[16]}, 0);
      bus_write(2'd0, ctl(0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0));
      check(spi_cs == 3'b111 && spi_sclk == 0, "R10 abort idle", {28'h0, spi_cs, spi_sclk}, 32'hE);
      bus_read(2'd0, 0, v);
      check(v[17] == 0 && v[18] == 1, "R10 no rx byte", {30'h0, v[18:17]}, 32'h2);

      // R4: polarity mixes
      bus_write(2'd0, ctl(2, 0, 0, 0, 0, 0, 3'b110, 0, 0, 0));
      check(spi_cs == 3'b001, "R4 idle with pol", {29'h0, spi_cs}, 32'h1);
      bus_write(2'd0, ctl(2, 0, 0, 1, 0, 0, 3'b110, 0, 0, 0));
      check(spi_cs == 3'b101, "R4 active high line 2", {29'h0, spi_cs}, 32'h5);
      bus_write(2'd0, ctl(3, 0, 0, 1, 0, 0, 3'b110, 0, 0, 0));
      check(spi_cs == 3'b001, "R4 index 3 none", {29'h0, spi_cs}, 32'h1);
      bus_write(2'd0, ctl(0, 0, 0, 1, 0, 0, 3'b000, 1, 0, 0));
      check(spi_cs == 3'b001, "R4 global polarity", {29'h0, spi_cs}, 32'h1);
      bus_write(2'd0, ctl(0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0));

      // R5/R6/R7: fill the transmit queue idle, flush it
      bus_write(2'd2, 32'd2);
      for (int i = 0; i < 16; i++) bus_write(2'd1, 32'(i));
      bus_read(2'd0, 0, v);
      check(v[18] == 0, "R5 tx full", {31'h0, v[18]}, 0);
      tg = toggles;
      bus_write(2'd0, ctl(0, 0, 0, 0, 0, 0, 3'b000, 0, 1, 0));
      bus_read(2'd0, 0, v);
      check(v[18] == 1 && v[5:4] == 2'b00, "R6 tx flush", {29'h0, v[18], v[5:4]}, 32'h4);
      bus_write(2'd0, ctl(0, 0, 0, 1, 0, 0, 3'b000, 0, 0, 0));
      bus_read(2'd0, 0, v);
      check(v[16] == 1 && toggles == tg, "R7 drained empty queue", {31'h0, v[16]}, 1);

      // R8/R9: overfill receive queue, stall, interrupts
      mon_cpol = 0; mon_cpha = 0; nbits = 0; mon_en = 1;
      bus_write(2'd0, ctl(0, 0, 0, 1, 0, 1, 3'b000, 0, 0, 0));
      for (int i = 0; i < 18; i++) send(8'(8'h20 + i * 7));
      repeat (800) @(negedge clk);
      bus_read(2'd0, 0, v);
      check(v[20:19] == 2'b11 && v[16] == 0, "R9 rx full and stalled", {29'h0, v[20:19], v[16]}, 32'h6);
      check(irq == 1, "R8 high-water irq", {31'h0, irq}, 1);
      drain(18);
      wait_drained("R7 drained after stall");
      mon_en = 0;
      check(irq == 0, "R8 irq off below level", {31'h0, irq}, 0);
      bus_write(2'd0, ctl(0, 0, 0, 1, 1, 1, 3'b000, 0, 0, 0));
      check(irq == 1, "R8 drained irq", {31'h0, irq}, 1);
      bus_write(2'd0, ctl(0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0));
      check(irq == 0, "R8 irq cleared", {31'h0, irq}, 0);

      // R5/R6: receive flag and receive flush
      mon_en = 1; nbits = 0;
      bus_write(2'd0, ctl(1, 0, 0, 1, 0, 0, 3'b000, 0, 0, 0));
      send(8'h12); send(8'h34);
      wait_drained("R7 drained rx flush");
      mon_en = 0;
      bus_read(2'd0, 0, v);
      check(v[17] == 1, "R5 rx waiting", {31'h0, v[17]}, 1);
      bus_write(2'd0, ctl(1, 0, 0, 1, 0, 0, 3'b000, 0, 0, 1));
      void'(exp_rx.pop_front()); void'(exp_rx.pop_front());
      bus_read(2'd0, 0, v);
      check(v[17] == 0 && v[5:4] == 2'b00, "R6 rx flush", {29'h0, v[17], v[5:4]}, 0);
      bus_read(2'd1, 1, v);
      check(v == 0, "R9 empty port reads zero", v, 0);
      check(exp_mosi.size() == 0, "R9 all bytes shifted", exp_mosi.size(), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule